// File: doc/BRIEF.md
# Guarded Control Register Unlock Sequencer

This block owns a small supervisor control register that holds the watchdog period select, the power-up delay select and a block-protect flag. It sits behind a byte-level serial slave and sees only decoded events: an addressing event (read or write), a completed data byte with its position in the transaction, and a stop. It answers each addressing event and each data byte with an ack or a nack in the same cycle.

The register also carries two volatile enable latches: a general write enable and a register write enable. Nonvolatile bits change only after a three-step unlock. First the general enable is armed, then the register enable, then a commit byte is written. The commit starts a self-timed busy period, counted in ticks of a slow timebase input. While that period runs, every new addressing event is refused. A write-protect pin refuses all data bytes. A write is applied only at a stop that follows exactly one acknowledged data byte.

Top module: `ctlreg_unlock_seq`

## Requirements
- R1: After reset the register image `ctl_reg_o` reads 8'h61, and `busy_o` is low. The image layout, bit 7 down to bit 0, is: power-up select high bit, watchdog select high bit, watchdog select low bit, block-protect, constant 0, register write enable, write enable, power-up select low bit. So the default is watchdog select 11 and power-up select 01.
- R2: A completed write of byte 8'h02, made while the register enable is clear, sets the write enable at the stop. No busy period follows.
- R3: A completed write of byte 8'h06, made while the write enable is set and the register enable is clear, sets the register enable. The register enable is never set while the write enable is clear.
- R4: While the register enable is set, a completed write whose bits [3:1] are 001 copies bits 7, 6, 5, 4 and 0 into the nonvolatile fields and clears the register enable. It also starts a busy period of exactly BUSY_TICKS tick pulses. The nonvolatile fields change only in the cycle after a stop.
- R5: While the register enable is set, a completed write whose bits [3:1] are 011 leaves the nonvolatile fields unchanged and keeps both enables set.
- R6: While the write enable is clear, every data byte other than 8'h02 is nacked and the write leaves the register unchanged.
- R7: A data byte at transaction position other than 0, or any byte after the first in the same write, is nacked. It aborts the whole write: nothing changes at the stop.
- R8: While `wp_i` is high, every data byte is nacked and the write has no effect.
- R9: A stop that arrives with no acknowledged data byte in the transaction changes nothing.
- R10: While busy, addressing events are nacked, and bytes and stops that follow them have no effect. The addressing ack returns once the busy period has ended.
- R11: A read transaction between unlock steps does not clear either enable.
- R12: A completed write of 8'h00 clears both the write enable and the register enable, without touching the nonvolatile fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Addressing event for this register (pulse) |
| sel_read_i | input | 1 | Direction of the addressing event, 1 = read |
| byte_i | input | 1 | A data byte and its ack slot have completed (pulse) |
| byte_idx_i | input | IDX_W | Position of the data byte in the transaction, 0 = first |
| byte_data_i | input | 8 | Data byte value |
| stop_i | input | 1 | Stop condition (pulse) |
| wp_i | input | 1 | Write-protect level |
| tick_i | input | 1 | Busy-period timebase pulse |
| addr_ack_o | output | 1 | Ack for the addressing event in the same cycle |
| data_ack_o | output | 1 | Ack for the data byte in the same cycle |
| ctl_reg_o | output | 8 | Register image |
| busy_o | output | 1 | Nonvolatile cycle in progress |

## Verification
The enable latches appear in the register image, so a wrong latch state shows up in `ctl_reg_o` in the cycle after the stop. It also changes the ack on the very next data byte. A stale pending byte or a missed abort only becomes visible at the following stop, when the image updates or fails to update. A mis-loaded busy counter shows as `busy_o` ending one tick early or late, and as a wrong addressing ack once it has ended. The bench compares the image and busy flag against its model every cycle, and checks each ack in the cycle it is given.

// File: rtl/ctlseq_pkg.sv
package ctlseq_pkg;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_SET_WEL,
    ACT_SET_RWEL,
    ACT_COMMIT,
    ACT_CLEAR
  } ctl_act_e;

  typedef struct packed {
    logic pup_hi;
    logic wd_hi;
    logic wd_lo;
    logic bprot;
    logic pup_lo;
  } nv_bits_t;

  localparam logic [7:0] BYTE_ARM    = 8'h02;
  localparam logic [7:0] BYTE_UNLOCK = 8'h06;
  localparam logic [7:0] BYTE_DISARM = 8'h00;

  // Decode of an accepted byte, given the enable latches at the stop.
  function automatic ctl_act_e classify(input logic [7:0] b,
                                        input logic wel,
                                        input logic rwel);
    ctl_act_e act;
    act = ACT_NONE;
    if (rwel) begin
      if (b[3:1] == 3'b001)      act = ACT_COMMIT;
      else if (b[3:1] == 3'b011) act = ACT_SET_RWEL;
      else if (b == BYTE_DISARM) act = ACT_CLEAR;
    end else begin
      if (b == BYTE_ARM)                  act = ACT_SET_WEL;
      else if (b == BYTE_UNLOCK && wel)   act = ACT_SET_RWEL;
      else if (b == BYTE_DISARM)          act = ACT_CLEAR;
    end
    return act;
  endfunction

endpackage

// File: rtl/ctlseq_txn.sv
module ctlseq_txn #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             sel_read_i,
  input  logic             accept_i,
  input  logic             byte_i,
  input  logic [IDX_W-1:0] byte_idx_i,
  input  logic [7:0]       byte_data_i,
  input  logic             stop_i,
  input  logic             wp_i,
  input  logic             wel_i,
  output logic             data_ack_o,
  output logic             done_o,
  output logic [7:0]       done_byte_o
);
  import ctlseq_pkg::*;

  logic       open_q, open_d;
  logic       have_q, have_d;
  logic       abort_q, abort_d;
  logic [7:0] byte_q, byte_d;
  logic       byte_en;

  always_comb begin
    data_ack_o = byte_i && open_q && !wp_i && (byte_idx_i == '0) && !have_q &&
                 ((byte_data_i == BYTE_ARM) || wel_i);
    done_o      = stop_i && !sel_i && !byte_i && open_q && have_q && !abort_q;
    done_byte_o = byte_q;
  end

  always_comb begin
    open_d  = open_q;
    have_d  = have_q;
    abort_d = abort_q;
    byte_d  = byte_q;
    byte_en = 1'b0;
    if (sel_i) begin
      open_d  = !sel_read_i && accept_i;
      have_d  = 1'b0;
      abort_d = 1'b0;
    end else if (byte_i) begin
      if (data_ack_o) begin
        have_d  = 1'b1;
        byte_d  = byte_data_i;
        byte_en = 1'b1;
      end else if (open_q) begin
        abort_d = 1'b1;
      end
    end else if (stop_i) begin
      open_d  = 1'b0;
      have_d  = 1'b0;
      abort_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      have_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      open_q  <= open_d;
      have_q  <= have_d;
      abort_q <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       byte_q <= 8'h00;
    else if (byte_en) byte_q <= byte_d;
  end

endmodule

// File: rtl/ctlseq_latch.sv
module ctlseq_latch #(
  parameter logic [4:0] NV_DEFAULT = 5'b0_11_0_1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done_i,
  input  logic [7:0]            byte_i,
  output logic                  wel_o,
  output logic                  rwel_o,
  output ctlseq_pkg::nv_bits_t  nv_o,
  output logic                  commit_o
);
  import ctlseq_pkg::*;

  logic     wel_q, wel_d, rwel_q, rwel_d;
  nv_bits_t nv_q, nv_d;
  ctl_act_e act;

  always_comb begin
    act      = done_i ? classify(byte_i, wel_q, rwel_q) : ACT_NONE;
    wel_d    = wel_q;
    rwel_d   = rwel_q;
    nv_d     = nv_q;
    commit_o = 1'b0;
    case (act)
      ACT_SET_WEL:  wel_d = 1'b1;
      ACT_SET_RWEL: begin wel_d = 1'b1; rwel_d = 1'b1; end
      ACT_COMMIT: begin
        nv_d     = '{pup_hi: byte_i[7], wd_hi: byte_i[6], wd_lo: byte_i[5],
                     bprot: byte_i[4], pup_lo: byte_i[0]};
        rwel_d   = 1'b0;
        commit_o = 1'b1;
      end
      ACT_CLEAR: begin wel_d = 1'b0; rwel_d = 1'b0; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
    end else if (done_i) begin
      wel_q  <= wel_d;
      rwel_q <= rwel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        nv_q <= NV_DEFAULT;
    else if (commit_o) nv_q <= nv_d;
  end

  assign wel_o  = wel_q;
  assign rwel_o = rwel_q;
  assign nv_o   = nv_q;

endmodule

// File: rtl/ctlseq_busy.sv
module ctlseq_busy #(
  parameter int BUSY_TICKS = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic tick_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(BUSY_TICKS + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(BUSY_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_i) begin
      cnt_d  = LOAD_VAL;
      cnt_en = 1'b1;
    end else if (tick_i && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/ctlreg_unlock_seq.sv
module ctlreg_unlock_seq #(
  parameter int         IDX_W      = 4,
  parameter int         BUSY_TICKS = 10000,
  parameter logic [4:0] NV_DEFAULT = 5'b0_11_0_1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             sel_read_i,
  input  logic             byte_i,
  input  logic [IDX_W-1:0] byte_idx_i,
  input  logic [7:0]       byte_data_i,
  input  logic             stop_i,
  input  logic             wp_i,
  input  logic             tick_i,
  output logic             addr_ack_o,
  output logic             data_ack_o,
  output logic [7:0]       ctl_reg_o,
  output logic             busy_o
);
  import ctlseq_pkg::*;

  logic     rst_meta, rst_sync;
  logic     wel, rwel, done, commit;
  logic [7:0] done_byte;
  nv_bits_t nv;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ctlseq_txn #(.IDX_W(IDX_W)) u_txn (
    .clk(clk), .rst_n(rst_sync),
    .sel_i(sel_i), .sel_read_i(sel_read_i), .accept_i(!busy_o),
    .byte_i(byte_i), .byte_idx_i(byte_idx_i), .byte_data_i(byte_data_i),
    .stop_i(stop_i), .wp_i(wp_i), .wel_i(wel),
    .data_ack_o(data_ack_o), .done_o(done), .done_byte_o(done_byte)
  );

  ctlseq_latch #(.NV_DEFAULT(NV_DEFAULT)) u_latch (
    .clk(clk), .rst_n(rst_sync),
    .done_i(done), .byte_i(done_byte),
    .wel_o(wel), .rwel_o(rwel), .nv_o(nv), .commit_o(commit)
  );

  ctlseq_busy #(.BUSY_TICKS(BUSY_TICKS)) u_busy (
    .clk(clk), .rst_n(rst_sync),
    .load_i(commit), .tick_i(tick_i), .busy_o(busy_o)
  );

  assign addr_ack_o = sel_i && !busy_o;
  assign ctl_reg_o  = {nv.pup_hi, nv.wd_hi, nv.wd_lo, nv.bprot, 1'b0, rwel, wel, nv.pup_lo};

endmodule

// File: rtl/ctlreg_unlock_seq_chk.sv
module ctlreg_unlock_seq_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_i,
  input logic             byte_i,
  input logic [IDX_W-1:0] byte_idx_i,
  input logic [7:0]       byte_data_i,
  input logic             stop_i,
  input logic             wp_i,
  input logic             addr_ack_o,
  input logic             data_ack_o,
  input logic [7:0]       ctl_reg_o,
  input logic             busy_o
);

  logic [4:0] nv_view;
  assign nv_view = {ctl_reg_o[7:4], ctl_reg_o[0]};

  assert_rwel_needs_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reg_o[2] |-> ctl_reg_o[1]);

  assert_nv_only_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_i |=> $stable(nv_view));

  assert_nv_change_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_view != $past(nv_view)) |-> busy_o);

  assert_locked_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_i && !ctl_reg_o[1] && byte_data_i != 8'h02) |-> !data_ack_o);

  assert_extra_byte_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_i && byte_idx_i != '0) |-> !data_ack_o);

  assert_wp_nack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_i && wp_i) |-> !data_ack_o);

  assert_busy_addr_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && busy_o) |-> !addr_ack_o);

endmodule

bind ctlreg_unlock_seq ctlreg_unlock_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .byte_i(byte_i),
  .byte_idx_i(byte_idx_i), .byte_data_i(byte_data_i), .stop_i(stop_i),
  .wp_i(wp_i), .addr_ack_o(addr_ack_o), .data_ack_o(data_ack_o),
  .ctl_reg_o(ctl_reg_o), .busy_o(busy_o)
);

// File: tb/sim_ctlreg_unlock_seq.sv
`timescale 1ns/1ps
module sim_ctlreg_unlock_seq;
  localparam int IDX_W = 4;
  localparam int BUSY  = 4;

  logic clk, rst_n;
  logic sel, rd, byt, stp, wp, tck;
  logic [IDX_W-1:0] idx;
  logic [7:0] dat;
  logic addr_ack, data_ack, busy;
  logic [7:0] creg;

  int checks = 0, failures = 0;
  bit armed = 0;

  ctlreg_unlock_seq #(.IDX_W(IDX_W), .BUSY_TICKS(BUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sel_read_i(rd), .byte_i(byt),
    .byte_idx_i(idx), .byte_data_i(dat), .stop_i(stp), .wp_i(wp), .tick_i(tck),
    .addr_ack_o(addr_ack), .data_ack_o(data_ack), .ctl_reg_o(creg), .busy_o(busy)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // ---------------- behavioural reference ----------------
  bit m_open, m_have, m_abort, m_wel, m_rwel;
  bit [7:0] m_byte;
  bit [4:0] m_nv;   // {pup1, wd1, wd0, bp, pup0}
  int m_cnt;

  function automatic bit [7:0] exp_reg();
    return {m_nv[4:1], 1'b0, m_rwel, m_wel, m_nv[0]};
  endfunction
  function automatic bit exp_addr_ack();
    return m_cnt == 0;
  endfunction
  function automatic bit exp_data_ack();
    return m_open && !wp && idx == 0 && !m_have && (dat == 8'h02 || m_wel);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_open <= 0; m_have <= 0; m_abort <= 0; m_byte <= 0;
      m_wel <= 0; m_rwel <= 0; m_nv <= 5'b01101; m_cnt <= 0;
    end else begin
      if (tck && m_cnt > 0) m_cnt <= m_cnt - 1;
      if (sel) begin
        m_open <= !rd && m_cnt == 0; m_have <= 0; m_abort <= 0;
      end else if (byt) begin
        if (exp_data_ack()) begin m_have <= 1; m_byte <= dat; end
        else if (m_open) m_abort <= 1;
      end else if (stp) begin
        m_open <= 0; m_have <= 0; m_abort <= 0;
        if (m_open && m_have && !m_abort) begin
          if (m_rwel) begin
            if (m_byte[3:1] == 3'b001) begin
              m_nv <= {m_byte[7:4], m_byte[0]}; m_rwel <= 0; m_cnt <= BUSY;
            end else if (m_byte[3:1] == 3'b011) begin
              m_wel <= 1; m_rwel <= 1;
            end else if (m_byte == 8'h00) begin
              m_wel <= 0; m_rwel <= 0;
            end
          end else begin
            if (m_byte == 8'h02) m_wel <= 1;
            else if (m_byte == 8'h06 && m_wel) begin m_wel <= 1; m_rwel <= 1; end
            else if (m_byte == 8'h00) begin m_wel <= 0; m_rwel <= 0; end
          end
        end
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      chk("R1 model image", creg, exp_reg());
      chk("R10 model busy", {7'd0, busy}, {7'd0, m_cnt != 0});
    end
  end

  task automatic ev(input logic s, input logic r, input logic b,
                    input logic [IDX_W-1:0] ix, input logic [7:0] d,
                    input logic st, input logic t, input string tag);
    @(negedge clk);
    sel = s; rd = r; byt = b; idx = ix; dat = d; stp = st; tck = t;
    #1;
    if (s) chk({tag, " addr ack"}, {7'd0, addr_ack}, {7'd0, exp_addr_ack()});
    if (b) chk({tag, " data ack"}, {7'd0, data_ack}, {7'd0, exp_data_ack()});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) ev(0, 0, 0, '0, 8'h00, 0, 0, "idle");
  endtask

  task automatic wr(input string tag, input logic [7:0] d, input logic exp_ack);
    logic got;
    ev(1, 0, 0, '0, 8'h00, 0, 0, tag);
    ev(0, 0, 1, '0, d, 0, 0, tag);
    got = data_ack;
    chk({tag, " fixed ack"}, {7'd0, got}, {7'd0, exp_ack});
    ev(0, 0, 0, '0, 8'h00, 1, 0, tag);
    idle(1);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 0; sel = 0; rd = 0; byt = 0; stp = 0; wp = 0; tck = 0; idx = '0; dat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    armed = 1;

    // R1 reset image and layout
    chk("R1 reset image", creg, 8'h61);
    chk("R1 reset busy", {7'd0, busy}, 8'h00);

    // R6 locked: unlock and commit bytes are ignored
    wr("R6 06 while locked", 8'h06, 0);
    chk("R6 image unchanged", creg, 8'h61);
    wr("R6 92 while locked", 8'h92, 0);
    chk("R6 image unchanged2", creg, 8'h61);

    // R9 stop with no data byte
    ev(1, 0, 0, '0, 0, 0, 0, "R9"); ev(0, 0, 0, '0, 0, 1, 0, "R9"); idle(1);
    chk("R9 empty write", creg, 8'h61);

    // R2 arm
    wr("R2 arm", 8'h02, 1);
    chk("R2 wel set", creg, 8'h63);
    chk("R2 no busy", {7'd0, busy}, 8'h00);

    // R11 read between steps
    ev(1, 1, 0, '0, 0, 0, 0, "R11"); idle(2); ev(0, 0, 0, '0, 0, 1, 0, "R11"); idle(1);
    chk("R11 read keeps wel", creg, 8'h63);

    // R3 unlock
    wr("R3 unlock", 8'h06, 1);
    chk("R3 rwel set", creg, 8'h67);

    // R11 read again with both latches set
    ev(1, 1, 0, '0, 0, 0, 0, "R11b"); ev(0, 0, 0, '0, 0, 1, 0, "R11b"); idle(1);
    chk("R11 read keeps rwel", creg, 8'h67);

    // R5 hold form qxys011r
    wr("R5 hold", 8'hF6, 1);
    chk("R5 nv kept", creg, 8'h67);

    // R7 second byte aborts
    ev(1, 0, 0, '0, 0, 0, 0, "R7");
    ev(0, 0, 1, '0, 8'h92, 0, 0, "R7");
    chk("R7 first ack", {7'd0, data_ack}, 8'h01);
    ev(0, 0, 1, 4'd1, 8'h92, 0, 0, "R7");
    chk("R7 second nack", {7'd0, data_ack}, 8'h00);
    ev(0, 0, 0, '0, 0, 1, 0, "R7"); idle(1);
    chk("R7 aborted", creg, 8'h67);

    // R8 write protect
    wp = 1;
    wr("R8 protected", 8'h92, 0);
    chk("R8 unchanged", creg, 8'h67);
    wp = 0;

    // R9 again with the unlock armed
    ev(1, 0, 0, '0, 0, 0, 0, "R9b"); ev(0, 0, 0, '0, 0, 1, 0, "R9b"); idle(1);
    chk("R9 empty keeps rwel", creg, 8'h67);

    // R4 commit
    wr("R4 commit", 8'h92, 1);
    chk("R4 committed image", creg, 8'h92);
    chk("R4 busy", {7'd0, busy}, 8'h01);

    // R10 busy refuses addressing
    ev(1, 0, 0, '0, 0, 0, 0, "R10");
    chk("R10 addr nack", {7'd0, addr_ack}, 8'h00);
    ev(0, 0, 1, '0, 8'h00, 0, 0, "R10");
    chk("R10 byte nack", {7'd0, data_ack}, 8'h00);
    ev(0, 0, 0, '0, 0, 1, 0, "R10"); idle(1);
    chk("R10 no effect", creg, 8'h92);
    for (int i = 0; i < BUSY - 1; i++) begin ev(0, 0, 0, '0, 0, 0, 1, "R4 tick"); idle(1); end
    chk("R4 still busy", {7'd0, busy}, 8'h01);
    ev(0, 0, 0, '0, 0, 0, 1, "R4 tick"); idle(1);
    chk("R4 busy over", {7'd0, busy}, 8'h00);
    ev(1, 0, 0, '0, 0, 0, 0, "R10b");
    chk("R10 addr ack back", {7'd0, addr_ack}, 8'h01);
    ev(0, 0, 0, '0, 0, 1, 0, "R10b"); idle(1);

    // R12 disarm
    wr("R12 disarm", 8'h00, 1);
    chk("R12 latches clear", creg, 8'h90);

    // full three-step [02,06,02] clears the nonvolatile fields
    wr("R2 arm2", 8'h02, 1);
    wr("R3 unlock2", 8'h06, 1);
    chk("R3 rwel2", creg, 8'h96);
    wr("R4 commit zero", 8'h02, 1);
    chk("R4 zero image", creg, 8'h02);
    for (int i = 0; i < BUSY; i++) begin ev(0, 0, 0, '0, 0, 0, 1, "R4 tick"); idle(1); end
    chk("R4 busy done2", {7'd0, busy}, 8'h00);

    idle(2);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule